// File: doc/BRIEF.md
# Keyed configuration port controller

This block is the configuration front end of a legacy I/O-mapped peripheral. It answers at two adjacent I/O addresses: an index port at the base address and a data port one address above it. The base is one of two strap-selected addresses. Out of reset the block is locked. A host must write a fixed key value to the index port twice in a row before any configuration register becomes visible. A separate close key written to the index port locks the block again.

While the block is unlocked, a write to the index port picks a configuration register, and data-port reads and writes reach that register. Indexes below 0x30 are global. They hold a logical-device select register and read-only identification bytes: device ID, revision and vendor ID. Indexes from 0x30 upward belong to the logical device chosen by the select register. Such an access is forwarded on a per-device request lane, and the device answers on the same lane. By convention the GPIO function sits on lane 6.

The host side is a valid/ready request channel and a valid/ready read-response channel. The block accepts one request at a time. It holds `req_ready` low until the request is fully retired, which includes the handshake of its read response. A read response stays on the bus, unchanged, until the host takes it. Toward a device, a forwarded access holds its request payload until the device gives ready. A forwarded read then waits for read data from that device for as long as the device needs.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, the index latch holds 0x00, the device select holds 0x00, `req_ready` is high, and no response or device request is pending.
- R2: The block unlocks only when the key 0x87 is written to the index port on two index-port writes in a row. Any other index-port write after a single 0x87 returns the key detector to idle. Data-port accesses between the two keys neither count toward the key nor break the sequence.
- R3: Writing 0xAA to the index port while unlocked locks the block, and the index latch keeps its value. While locked, 0xAA has no effect.
- R4: While locked, data-port writes change nothing and start no device request, data-port reads return 0xFF, index-port reads return 0xFF, and index-port writes other than keys do not load the index latch.
- R5: The index port is at the base address and the data port at base+1. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Requests to any other address are consumed with no effect and produce no response.
- R6: While unlocked, index 0x07 is the device select register: data-port writes load it and data-port reads return it. Reading the index port returns the index latch.
- R7: While unlocked, the read-only bytes are: index 0x20 returns device ID[15:8], 0x21 returns device ID[7:0], 0x22 returns the revision, 0x23 returns vendor ID[15:8], and 0x24 returns vendor ID[7:0]. Other indexes below 0x30 read 0x00. Writes to any index below 0x30 other than 0x07 have no effect.
- R8: While unlocked, a data-port access at an index of 0x30 or above raises `dev_valid[n]` alone, where n is the device select. The request carries `dev_write`, `dev_index` and `dev_wdata`, and all of these stay stable until the handshake cycle in which `dev_ready[n]` is high.
- R9: For a forwarded read, the response data is `dev_rdata[8n+7:8n]` taken in the first cycle, at or after the handshake, in which `dev_rvalid[n]` is high. A forwarded write completes at its handshake and produces no response.
- R10: `req_ready` is low from the acceptance of a request until it retires. A raised `rsp_valid` stays high, with `rsp_data` unchanged, until the cycle in which `rsp_ready` is high.
- R11: When the device select is NUM_LD or above, forwarded accesses raise no `dev_valid` line. Such writes are dropped and such reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Base address strap: 0 for 0x2E, 1 for 0x4E |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Host I/O address |
| req_wdata | input | 8 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response data |
| dev_valid | output | NUM_LD | Per-device request strobe, at most one high |
| dev_ready | input | NUM_LD | Per-device request accept |
| dev_write | output | 1 | Forwarded access is a write |
| dev_index | output | 8 | Forwarded register index |
| dev_wdata | output | 8 | Forwarded write data |
| dev_rvalid | input | NUM_LD | Per-device read data valid |
| dev_rdata | input | 8*NUM_LD | Per-device read data, lane n in bits [8n+7:8n] |

## Verification
Two events can land in the same cycle: a device's acceptance of a forwarded read, and that device's return of the read data. The bench's device model varies both its accept delay and its read-data delay, including zero for each, so that the combined case and the separated case each occur across a sweep of all 256 indexes. Each response is compared with a value the bench computes from the index and the selected lane. The second overlap is a held response meeting a new request. The bench stalls `rsp_ready` for several cycles and checks that `rsp_data` does not move and that `req_ready` stays low.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN     = 8'h87;
  localparam logic [7:0] KEY_CLOSE    = 8'hAA;
  localparam logic [7:0] IDX_LDSEL    = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_VEND_HI  = 8'h23;
  localparam logic [7:0] IDX_VEND_LO  = 8'h24;
  localparam logic [7:0] IDX_FWD_BASE = 8'h30;
  localparam logic [7:0] LOCKED_READ  = 8'hFF;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_BUSY, TX_RESP} tx_state_e;
  typedef enum logic [1:0] {BR_IDLE, BR_REQ, BR_WAIT} br_state_e;

  typedef struct packed {
    logic       write;
    logic [7:0] sel;
    logic [7:0] index;
    logic [7:0] wdata;
  } fwd_cmd_t;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] idx_data,
  output logic       unlocked
);
  key_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (idx_wr) begin
      case (st)
        KS_LOCKED: if (idx_data == KEY_OPEN) st_nx = KS_HALF;
        KS_HALF:   st_nx = (idx_data == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (idx_data == KEY_CLOSE) st_nx = KS_LOCKED;
        default:   st_nx = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KS_LOCKED;
    else        st <= st_nx;
  end

  assign unlocked = (st == KS_OPEN);

  // R2: opening only follows a key write
  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && idx_data == KEY_OPEN));

  // R3: close key always locks
  assert_close_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && idx_data == KEY_CLOSE) |=> !unlocked);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID   = 16'hC5A1,
  parameter logic [7:0]  REVISION = 8'h03,
  parameter logic [15:0] VEND_ID  = 16'h5A3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index_q,
  output logic [7:0] ldsel_q,
  output logic [7:0] local_rdata,
  output logic       is_fwd
);
  logic load_index, load_ldsel;

  assign load_index = idx_wr && unlocked && (wdata != KEY_CLOSE);
  assign load_ldsel = dat_wr && unlocked && (index_q == IDX_LDSEL);
  assign is_fwd     = (index_q >= IDX_FWD_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldsel_q <= 8'h00;
    end else begin
      if (load_index) index_q <= wdata;
      if (load_ldsel) ldsel_q <= wdata;
    end
  end

  always_comb begin
    case (index_q)
      IDX_LDSEL:    local_rdata = ldsel_q;
      IDX_DEVID_HI: local_rdata = DEV_ID[15:8];
      IDX_DEVID_LO: local_rdata = DEV_ID[7:0];
      IDX_REV:      local_rdata = REVISION;
      IDX_VEND_HI:  local_rdata = VEND_ID[15:8];
      IDX_VEND_LO:  local_rdata = VEND_ID[7:0];
      default:      local_rdata = 8'h00;
    endcase
  end

  // R4: select register frozen while locked
  assert_ldsel_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ldsel_q));

  // R4: index latch frozen while locked
  assert_index_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(index_q));
endmodule

// File: rtl/sio_ld_bridge.sv
module sio_ld_bridge
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LD = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  fwd_cmd_t            cmd,
  output logic                done,
  output logic [7:0]          done_rdata,
  output logic [NUM_LD-1:0]   dev_valid,
  input  logic [NUM_LD-1:0]   dev_ready,
  output logic                dev_write,
  output logic [7:0]          dev_index,
  output logic [7:0]          dev_wdata,
  input  logic [NUM_LD-1:0]   dev_rvalid,
  input  logic [NUM_LD*8-1:0] dev_rdata
);
  br_state_e st, st_nx;
  fwd_cmd_t  cmd_q;

  logic [NUM_LD-1:0] lane_hit;
  logic [7:0]        lane_data [NUM_LD];
  logic              lane_ok, sel_ready, sel_rvalid;
  logic [7:0]        sel_rdata;

  for (genvar g = 0; g < NUM_LD; g++) begin : g_lane
    assign lane_hit[g]  = (cmd_q.sel == 8'(g));
    assign dev_valid[g] = (st == BR_REQ) && lane_hit[g];
    assign lane_data[g] = lane_hit[g] ? dev_rdata[g*8 +: 8] : 8'h00;
  end

  always_comb begin
    sel_rdata = 8'h00;
    for (int k = 0; k < NUM_LD; k++) sel_rdata = sel_rdata | lane_data[k];
  end

  assign lane_ok    = |lane_hit;
  assign sel_ready  = |(lane_hit & dev_ready);
  assign sel_rvalid = |(lane_hit & dev_rvalid);
  assign dev_write  = cmd_q.write;
  assign dev_index  = cmd_q.index;
  assign dev_wdata  = cmd_q.wdata;

  always_comb begin
    st_nx      = st;
    done       = 1'b0;
    done_rdata = LOCKED_READ;
    case (st)
      BR_IDLE: if (start) st_nx = BR_REQ;
      BR_REQ: begin
        if (!lane_ok) begin
          done  = 1'b1;
          st_nx = BR_IDLE;
        end else if (sel_ready) begin
          if (cmd_q.write) begin
            done  = 1'b1;
            st_nx = BR_IDLE;
          end else if (sel_rvalid) begin
            done       = 1'b1;
            done_rdata = sel_rdata;
            st_nx      = BR_IDLE;
          end else begin
            st_nx = BR_WAIT;
          end
        end
      end
      BR_WAIT: if (sel_rvalid) begin
        done       = 1'b1;
        done_rdata = sel_rdata;
        st_nx      = BR_IDLE;
      end
      default: st_nx = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= BR_IDLE;
      cmd_q <= '0;
    end else begin
      st <= st_nx;
      if (start && st == BR_IDLE) cmd_q <= cmd;
    end
  end

  // R8: at most one device lane requested
  assert_lane_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_valid));

  // R8: request and payload held until accepted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_valid && !(|(dev_valid & dev_ready))) |=>
      (dev_valid == $past(dev_valid)) && $stable(dev_index) &&
      $stable(dev_wdata) && $stable(dev_write));

  // R11: an absent lane completes without any request
  assert_absent_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BR_REQ && !lane_ok) |-> (done && dev_valid == '0 && done_rdata == LOCKED_READ));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     BASE_LO  = 16'h002E,
  parameter logic [15:0]     BASE_HI  = 16'h004E,
  parameter int              NUM_LD   = 8,
  parameter logic [15:0]     DEV_ID   = 16'hC5A1,
  parameter logic [7:0]      REVISION = 8'h03,
  parameter logic [15:0]     VEND_ID  = 16'h5A3C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_sel,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [7:0]          req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [7:0]          rsp_data,
  output logic [NUM_LD-1:0]   dev_valid,
  input  logic [NUM_LD-1:0]   dev_ready,
  output logic                dev_write,
  output logic [7:0]          dev_index,
  output logic [7:0]          dev_wdata,
  input  logic [NUM_LD-1:0]   dev_rvalid,
  input  logic [NUM_LD*8-1:0] dev_rdata
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] BASE_B = ADDR_W'(BASE_HI);

  tx_state_e   tx;
  logic [ADDR_W-1:0] base;
  logic        hit_idx, hit_dat, accept;
  logic        idx_wr, idx_rd, dat_wr, dat_rd, fwd_start;
  logic        unlocked, is_fwd, pend_read;
  logic [7:0]  index_q, ldsel_q, local_rdata;
  logic        br_done;
  logic [7:0]  br_rdata;
  logic [7:0]  rsp_q;
  fwd_cmd_t    cmd;

  assign base      = base_sel ? BASE_B : BASE_A;
  assign hit_idx   = (req_addr == base);
  assign hit_dat   = (req_addr == base + ADDR_W'(1));
  assign req_ready = (tx == TX_IDLE);
  assign accept    = req_valid && req_ready;
  assign idx_wr    = accept &&  req_write && hit_idx;
  assign idx_rd    = accept && !req_write && hit_idx;
  assign dat_wr    = accept &&  req_write && hit_dat;
  assign dat_rd    = accept && !req_write && hit_dat;
  assign fwd_start = unlocked && is_fwd && (dat_wr || dat_rd);

  assign cmd.write = req_write;
  assign cmd.sel   = ldsel_q;
  assign cmd.index = index_q;
  assign cmd.wdata = req_wdata;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(req_wdata),
    .unlocked(unlocked)
  );

  sio_cfg_regs #(.DEV_ID(DEV_ID), .REVISION(REVISION), .VEND_ID(VEND_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(req_wdata), .index_q(index_q), .ldsel_q(ldsel_q),
    .local_rdata(local_rdata), .is_fwd(is_fwd)
  );

  sio_ld_bridge #(.NUM_LD(NUM_LD)) u_bridge (
    .clk(clk), .rst_n(rst_n), .start(fwd_start), .cmd(cmd),
    .done(br_done), .done_rdata(br_rdata),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_write(dev_write),
    .dev_index(dev_index), .dev_wdata(dev_wdata),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx        <= TX_IDLE;
      rsp_q     <= 8'h00;
      pend_read <= 1'b0;
    end else begin
      case (tx)
        TX_IDLE: begin
          if (fwd_start) begin
            tx        <= TX_BUSY;
            pend_read <= dat_rd;
          end else if (idx_rd) begin
            tx    <= TX_RESP;
            rsp_q <= unlocked ? index_q : LOCKED_READ;
          end else if (dat_rd) begin
            tx    <= TX_RESP;
            rsp_q <= unlocked ? local_rdata : LOCKED_READ;
          end
        end
        TX_BUSY: if (br_done) begin
          tx <= pend_read ? TX_RESP : TX_IDLE;
          if (pend_read) rsp_q <= br_rdata;
        end
        TX_RESP: if (rsp_ready) tx <= TX_IDLE;
        default: tx <= TX_IDLE;
      endcase
    end
  end

  assign rsp_valid = (tx == TX_RESP);
  assign rsp_data  = rsp_q;

  // R10: response held until taken
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10: no new acceptance while a response waits
  assert_no_accept_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R5: a local read at a decoded port is answered next cycle
  assert_local_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx_rd || dat_rd) && !fwd_start) |=> rsp_valid);

  // R4: locked data access never starts a device request
  assert_locked_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && (dat_wr || dat_rd)) |=> (dev_valid == '0));
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int          NUM_LD = 8;
  localparam logic [15:0] DEVID  = 16'hC5A1;
  localparam logic [7:0]  REV    = 8'h03;
  localparam logic [15:0] VEND   = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_sel = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic [NUM_LD-1:0] dev_valid, dev_ready, dev_rvalid;
  logic dev_write;
  logic [7:0] dev_index, dev_wdata;
  logic [NUM_LD*8-1:0] dev_rdata;

  int checks = 0, fails = 0;
  int ready_lat = 0, rd_lat = 0, stall = 0;
  int last_lane = -1, fwd_count = 0, hold_err = 0;
  logic [7:0] mem [NUM_LD][256];

  always #5 clk = ~clk;

  sio_cfg_port #(.NUM_LD(NUM_LD), .DEV_ID(DEVID), .REVISION(REV), .VEND_ID(VEND)) uut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_write(dev_write),
    .dev_index(dev_index), .dev_wdata(dev_wdata),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] init_val(int l, int i);
    return 8'(l * 37 + i * 5 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // device model: per-lane accept and read-data latencies
  initial begin : dev_model
    int lane;
    logic wr;
    logic [7:0] idx, wd;
    logic [NUM_LD-1:0] v0;
    dev_ready = '0; dev_rvalid = '0; dev_rdata = '0;
    for (int l = 0; l < NUM_LD; l++)
      for (int i = 0; i < 256; i++) mem[l][i] = init_val(l, i);
    forever begin
      @(negedge clk);
      dev_ready = '0; dev_rvalid = '0;
      if (dev_valid != '0) begin
        lane = 0;
        for (int k = 0; k < NUM_LD; k++) if (dev_valid[k]) lane = k;
        last_lane = lane; fwd_count++;
        wr = dev_write; idx = dev_index; wd = dev_wdata; v0 = dev_valid;
        for (int w = 0; w < ready_lat; w++) begin
          @(negedge clk);
          if (dev_valid != v0 || dev_write != wr || dev_index != idx || dev_wdata != wd)
            hold_err++;
        end
        dev_ready[lane] = 1'b1;
        if (!wr && rd_lat == 0) begin
          dev_rvalid[lane] = 1'b1;
          dev_rdata[lane*8 +: 8] = mem[lane][idx];
        end
        @(negedge clk);
        dev_ready = '0; dev_rvalid = '0;
        if (dev_valid != '0) hold_err++;
        if (wr) mem[lane][idx] = wd;
        else if (rd_lat > 0) begin
          for (int w = 1; w < rd_lat; w++) @(negedge clk);
          dev_rvalid[lane] = 1'b1;
          dev_rdata[lane*8 +: 8] = mem[lane][idx];
          @(negedge clk);
          dev_rvalid = '0;
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    int n;
    bit held;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    d = rsp_data;
    if (!rsp_valid) chk(0, "R9 response timeout", 0, 1);
    if (stall > 0) begin
      held = 1'b1;
      for (int s = 0; s < stall; s++) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        if (!rsp_valid || rsp_data != d || req_ready) held = 1'b0;
      end
      req_valid = 1'b0;
      chk(held, "R10 response held under stall", int'(rsp_data), int'(d));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic rd_none(input logic [15:0] a);
    bit seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int s = 0; s < 5; s++) begin
      if (rsp_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R5 no response off-port", int'(seen), 0);
  endtask

  function automatic logic [7:0] exp_low(logic [7:0] i, logic [7:0] ls);
    case (i)
      8'h07: return ls;
      8'h20: return DEVID[15:8];
      8'h21: return DEVID[7:0];
      8'h22: return REV;
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      default: return 8'h00;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d, e;
    int fc;
    logic [15:0] IX, DT;
    IX = 16'h002E; DT = 16'h002F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && dev_valid == '0, "R1 idle after reset",
        {req_ready, rsp_valid}, 2);
    rd(DT, d); chk(d == 8'hFF, "R4 locked data read", d, 8'hFF);
    rd(IX, d); chk(d == 8'hFF, "R4 locked index read", d, 8'hFF);
    wr(IX, 8'h87); wr(IX, 8'h87);
    rd(IX, d); chk(d == 8'h00, "R1 index latch reset", d, 0);
    wr(IX, 8'h07);
    rd(DT, d); chk(d == 8'h00, "R1 select reset", d, 0);
    wr(IX, 8'hAA);
    rd(DT, d); chk(d == 8'hFF, "R3 locked after close", d, 8'hFF);
    rd(IX, d); chk(d == 8'hFF, "R3 index hidden after close", d, 8'hFF);

    // R2 sweep: single key then any other value never unlocks
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h87) begin
        wr(IX, 8'h87); wr(IX, 8'(v));
        rd(DT, d);
        chk(d == 8'hFF, $sformatf("R2 broken key 0x%0h", v), d, 8'hFF);
      end
    end
    // R2: data access between keys does not break the sequence
    wr(IX, 8'h87); rd(DT, d); wr(IX, 8'h87);
    rd(IX, d); chk(d == 8'h07, "R2 unlock with data access between keys", d, 8'h07);

    // R6 select register
    wr(DT, 8'h03);
    rd(DT, d); chk(d == 8'h03, "R6 select readback", d, 3);
    // R4 locked writes ignored
    wr(IX, 8'hAA);
    wr(DT, 8'h05); wr(IX, 8'h20);
    wr(IX, 8'h87); wr(IX, 8'h87);
    rd(IX, d); chk(d == 8'h07, "R4 index kept while locked", d, 7);
    rd(DT, d); chk(d == 8'h03, "R4 select kept while locked", d, 3);
    wr(IX, 8'h40); wr(IX, 8'hAA);
    fc = fwd_count;
    wr(DT, 8'h11); rd(DT, d);
    chk(d == 8'hFF && fwd_count == fc, "R4 no forward while locked", fwd_count, fc);
    // R3: close key while locked has no effect, sequence still works
    wr(IX, 8'hAA); wr(IX, 8'h87); wr(IX, 8'h87);
    rd(IX, d); chk(d == 8'h40, "R3 close while locked harmless", d, 8'h40);

    // R7 writes to read-only indexes ignored
    wr(IX, 8'h20); wr(DT, 8'h99);
    rd(DT, d); chk(d == DEVID[15:8], "R7 id write ignored", d, DEVID[15:8]);
    wr(IX, 8'h10); wr(DT, 8'h99);
    rd(DT, d); chk(d == 8'h00, "R7 unused low index", d, 0);

    // R7/R8/R9 sweep over all indexes on lane 6, varying latencies
    wr(IX, 8'h07); wr(DT, 8'h06);
    for (int i = 0; i < 256; i++) begin
      if (i != 8'hAA) begin
        ready_lat = i % 3; rd_lat = (i / 3) % 3;
        stall = (i % 17 == 0) ? 4 : 0;
        wr(IX, 8'(i));
        last_lane = -1;
        rd(DT, d);
        e = (i >= 8'h30) ? init_val(6, i) : exp_low(8'(i), 8'h06);
        chk(d == e, $sformatf("R9 R7 index 0x%0h read", i), d, e);
        if (i >= 8'h30)
          chk(last_lane == 6, "R8 lane selected", last_lane, 6);
      end
    end
    stall = 0;

    // R8/R9 forwarded writes then reads on every lane
    for (int l = 0; l < NUM_LD; l++) begin
      ready_lat = l % 3; rd_lat = (l + 1) % 3;
      wr(IX, 8'h07); wr(DT, 8'(l));
      wr(IX, 8'(8'h30 + l)); wr(DT, 8'(l * 17 + 1));
      rd(DT, d);
      chk(d == 8'(l * 17 + 1), $sformatf("R8 lane %0d write readback", l), d, l * 17 + 1);
    end
    chk(hold_err == 0, "R8 request held until accepted", hold_err, 0);

    // R11 absent lanes
    wr(IX, 8'h07); wr(DT, 8'(NUM_LD));
    fc = fwd_count;
    wr(IX, 8'h40); wr(DT, 8'h77); rd(DT, d);
    chk(d == 8'hFF && fwd_count == fc, "R11 absent lane", d, 8'hFF);
    wr(IX, 8'h07); wr(DT, 8'hFF);
    wr(IX, 8'h50); rd(DT, d);
    chk(d == 8'hFF && fwd_count == fc, "R11 lane 0xFF", d, 8'hFF);

    // R5 address decoding and base select
    rd_none(16'h0030);
    wr(IX, 8'hAA);
    base_sel = 1'b1;
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd_none(16'h002F);
    rd(16'h004F, d); chk(d == 8'hFF, "R5 old base ignored", d, 8'hFF);
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    rd(16'h004E, d); chk(d == 8'h50, "R5 alternate base index", d, 8'h50);
    wr(16'h004E, 8'h22);
    rd(16'h004F, d); chk(d == REV, "R5 alternate base data", d, REV);
    rd_none(16'h0050);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule